// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer with Jump Folding

This block sits beside the instruction fetch stage of a five-stage in-order pipeline. Every fetch cycle it looks up the fetch PC in a small direct-mapped table. A hit means "predict taken": the block returns the stored target as the next fetch PC. Each entry also holds a copy of the instruction found at the target. When the hit entry is marked unconditional, the block folds the jump away. It hands decode the stored target instruction in place of the fetched jump, and it steers fetch to the target plus 4. The jump therefore costs no cycle at all.

Only branches that resolve taken are kept in the table. Decode returns each resolved branch on a valid/ready stream. The stream carries the branch PC, the prediction that came with it, the actual outcome, the target, the target instruction word and an unconditional flag. The block accepts a resolution only while `res_ready` is high. The producer must hold `res_valid` and every field stable until it sees `res_ready` in the same cycle as `res_valid`.

A resolution that agrees with its prediction costs nothing and leaves the table alone. A resolution that disagrees starts a fixed two-cycle sequence. In the first cycle the table is written (an entry is allocated, or the entry is removed) and fetch is stalled. In the second cycle fetch is redirected to the correct address. `res_ready` stays low for both cycles.

Top module: `btb_fold_unit`

## Requirements
- R1: With `fetch_req` high and no penalty sequence running, `dec_pred` is high in the same cycle exactly when the slot chosen by PC bits [5:2] is valid and its stored tag equals PC bits [31:6].
- R2: On a hit whose entry is conditional, `next_pc` is the stored target, and `dec_insn`/`dec_pc` are the fetched word and the fetch PC.
- R3: On a miss, `next_pc` is the fetch PC plus 4 and `dec_insn` is `fetch_insn`, with `dec_fold` low.
- R4: On a hit whose entry is unconditional, `dec_fold` is high, `dec_insn` is the stored target instruction, `dec_pc` is the stored target and `next_pc` is the target plus 4.
- R5: An accepted resolution with `res_pred` equal to `res_taken` (a hit that is taken, or a miss that is not taken) raises neither `fetch_stall` nor `fetch_redirect`, and it leaves the table unchanged.
- R6: An accepted resolution with `res_pred`=1 and `res_taken`=0 gives exactly two penalty cycles. The cycle after acceptance has `fetch_stall` high and removes the entry. The next cycle has `fetch_redirect` high with `redirect_pc` = `res_pc`+4. After this the branch misses.
- R7: An accepted resolution with `res_pred`=0 and `res_taken`=1 gives exactly two penalty cycles. The first is a stall cycle that writes the entry with the PC, target, target word and unconditional flag. The second is a redirect cycle with `redirect_pc` = `res_target`. After this the branch hits.
- R8: Allocating a branch into a slot that already holds a different branch replaces the old entry, and the old branch then misses.
- R9: Reset clears every valid bit, so every lookup misses. Reset also deasserts `fetch_stall` and `fetch_redirect` and raises `res_ready`.
- R10: `res_ready` is low during both penalty cycles and high otherwise.
- R11: During a penalty cycle the table write takes priority over any lookup. `dec_valid` and `dec_pred` are low, even for a fetch PC that selects the slot being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch stage is presenting a PC this cycle |
| fetch_pc | input | 32 | PC being fetched |
| fetch_insn | input | 32 | Instruction word returned for `fetch_pc` |
| next_pc | output | 32 | PC the fetch stage should use next |
| dec_valid | output | 1 | An instruction is handed to decode this cycle |
| dec_pred | output | 1 | The lookup hit (predicted taken) |
| dec_fold | output | 1 | An unconditional jump was folded away |
| dec_pc | output | 32 | PC of the instruction handed to decode |
| dec_insn | output | 32 | Instruction handed to decode |
| res_valid | input | 1 | Resolution from decode is present |
| res_ready | output | 1 | Block can accept a resolution |
| res_pc | input | 32 | PC of the resolved branch |
| res_pred | input | 1 | Prediction the branch carried (its `dec_pred`) |
| res_taken | input | 1 | Actual outcome |
| res_uncond | input | 1 | Branch is unconditional |
| res_target | input | 32 | Actual target address |
| res_insn | input | 32 | Instruction word at the target |
| fetch_stall | output | 1 | Table-update penalty cycle; no fetch |
| fetch_redirect | output | 1 | Restart penalty cycle; fetch reloads from `redirect_pc` |
| redirect_pc | output | 32 | Correct restart address |

## Verification
The bound checker checks the order of the penalty sequence on every cycle: stall, then redirect, then idle. It also checks that a disagreeing resolution always starts that sequence and an agreeing one never does, and that `res_ready`, `dec_valid` and `dec_pred` stay low while the sequence runs. A fold must always carry a next PC 4 past the substituted instruction. The bench alone can show what the table holds: that an allocation makes a later lookup hit with the right target and word, that a removal or a conflicting allocation makes it miss, and that reset empties the table. It also checks the exact redirect address and counts the penalty cycles for every hit/miss and taken/not-taken combination.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Penalty sequencer states: idle, table-update stall, fetch restart
  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_UPDATE  = 2'd1,
    SQ_RESTART = 2'd2
  } seq_state_t;
endpackage

// File: rtl/btb_table.sv
module btb_table #(
  parameter int XLEN    = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = XLEN - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [XLEN-1:0]  rd_target,
  output logic [XLEN-1:0]  rd_insn,
  output logic             rd_uncond,
  input  logic             wr_en,
  input  logic             wr_alloc,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [XLEN-1:0]  wr_target,
  input  logic [XLEN-1:0]  wr_insn,
  input  logic             wr_uncond
);
  logic             vld_q  [ENTRIES];
  logic [TAG_W-1:0] tag_q  [ENTRIES];
  logic [XLEN-1:0]  tgt_q  [ENTRIES];
  logic [XLEN-1:0]  word_q [ENTRIES];
  logic             unc_q  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));

    // valid bit: set on allocation, cleared only when the removed branch still owns the slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[e] <= 1'b0;
      end else if (sel) begin
        if (wr_alloc)
          vld_q[e] <= 1'b1;
        else if (tag_q[e] == wr_tag)
          vld_q[e] <= 1'b0;
      end
    end

    // payload has no reset; it is qualified by the valid bit
    always_ff @(posedge clk) begin
      if (sel && wr_alloc) begin
        tag_q[e]  <= wr_tag;
        tgt_q[e]  <= wr_target;
        word_q[e] <= wr_insn;
        unc_q[e]  <= wr_uncond;
      end
    end
  end

  always_comb begin
    rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    rd_target = tgt_q[rd_idx];
    rd_insn   = word_q[rd_idx];
    rd_uncond = unc_q[rd_idx];
  end
endmodule

// File: rtl/btb_seq.sv
module btb_seq
  import btb_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            res_valid,
  output logic            res_ready,
  input  logic [XLEN-1:0] res_pc,
  input  logic            res_pred,
  input  logic            res_taken,
  input  logic            res_uncond,
  input  logic [XLEN-1:0] res_target,
  input  logic [XLEN-1:0] res_insn,
  output logic            stall,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc,
  output logic            wr_en,
  output logic            wr_alloc,
  output logic [XLEN-1:0] wr_pc,
  output logic [XLEN-1:0] wr_target,
  output logic [XLEN-1:0] wr_insn,
  output logic            wr_uncond
);
  seq_state_t      st_q, st_d;
  logic [XLEN-1:0] pc_q, tgt_q, insn_q;
  logic            unc_q, alloc_q;
  logic            accept, wrong;

  assign res_ready = (st_q == SQ_IDLE);
  assign accept    = res_valid && res_ready;
  assign wrong     = res_pred != res_taken;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:    if (accept && wrong) st_d = SQ_UPDATE;
      SQ_UPDATE:  st_d = SQ_RESTART;
      SQ_RESTART: st_d = SQ_IDLE;
      default:    st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (accept && wrong) begin
      pc_q    <= res_pc;
      tgt_q   <= res_target;
      insn_q  <= res_insn;
      unc_q   <= res_uncond;
      alloc_q <= res_taken;
    end
  end

  assign stall       = (st_q == SQ_UPDATE);
  assign redirect    = (st_q == SQ_RESTART);
  assign redirect_pc = alloc_q ? tgt_q : pc_q + XLEN'(4);
  assign wr_en       = stall;
  assign wr_alloc    = alloc_q;
  assign wr_pc       = pc_q;
  assign wr_target   = tgt_q;
  assign wr_insn     = insn_q;
  assign wr_uncond   = unc_q;
endmodule

// File: rtl/btb_fetch_mux.sv
module btb_fetch_mux #(
  parameter int XLEN = 32
) (
  input  logic            fetch_req,
  input  logic [XLEN-1:0] fetch_pc,
  input  logic [XLEN-1:0] fetch_insn,
  input  logic            stall,
  input  logic            redirect,
  input  logic [XLEN-1:0] redirect_pc,
  input  logic            tbl_hit,
  input  logic [XLEN-1:0] tbl_target,
  input  logic [XLEN-1:0] tbl_insn,
  input  logic            tbl_uncond,
  output logic [XLEN-1:0] next_pc,
  output logic            dec_valid,
  output logic            dec_pred,
  output logic            dec_fold,
  output logic [XLEN-1:0] dec_pc,
  output logic [XLEN-1:0] dec_insn
);
  logic look_ok, hit, fold;

  assign look_ok = fetch_req && !stall && !redirect;
  assign hit     = look_ok && tbl_hit;
  assign fold    = hit && tbl_uncond;

  assign dec_valid = look_ok;
  assign dec_pred  = hit;
  assign dec_fold  = fold;
  assign dec_pc    = fold ? tbl_target : fetch_pc;
  assign dec_insn  = fold ? tbl_insn : fetch_insn;

  always_comb begin
    if (redirect)        next_pc = redirect_pc;
    else if (!look_ok)   next_pc = fetch_pc;
    else if (fold)       next_pc = tbl_target + XLEN'(4);
    else if (hit)        next_pc = tbl_target;
    else                 next_pc = fetch_pc + XLEN'(4);
  end
endmodule

// File: rtl/btb_fold_unit.sv
module btb_fold_unit #(
  parameter int XLEN    = 32,
  parameter int ENTRIES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_req,
  input  logic [XLEN-1:0] fetch_pc,
  input  logic [XLEN-1:0] fetch_insn,
  output logic [XLEN-1:0] next_pc,
  output logic            dec_valid,
  output logic            dec_pred,
  output logic            dec_fold,
  output logic [XLEN-1:0] dec_pc,
  output logic [XLEN-1:0] dec_insn,
  input  logic            res_valid,
  output logic            res_ready,
  input  logic [XLEN-1:0] res_pc,
  input  logic            res_pred,
  input  logic            res_taken,
  input  logic            res_uncond,
  input  logic [XLEN-1:0] res_target,
  input  logic [XLEN-1:0] res_insn,
  output logic            fetch_stall,
  output logic            fetch_redirect,
  output logic [XLEN-1:0] redirect_pc
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = XLEN - IDX_W - 2;

  logic            t_hit, t_unc;
  logic [XLEN-1:0] t_tgt, t_insn;
  logic            w_en, w_alloc, w_unc;
  logic [XLEN-1:0] w_pc, w_tgt, w_insn;

  btb_seq #(.XLEN(XLEN)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .res_pc     (res_pc),
    .res_pred   (res_pred),
    .res_taken  (res_taken),
    .res_uncond (res_uncond),
    .res_target (res_target),
    .res_insn   (res_insn),
    .stall      (fetch_stall),
    .redirect   (fetch_redirect),
    .redirect_pc(redirect_pc),
    .wr_en      (w_en),
    .wr_alloc   (w_alloc),
    .wr_pc      (w_pc),
    .wr_target  (w_tgt),
    .wr_insn    (w_insn),
    .wr_uncond  (w_unc)
  );

  btb_table #(.XLEN(XLEN), .ENTRIES(ENTRIES)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (fetch_pc[IDX_W+1:2]),
    .rd_tag   (fetch_pc[XLEN-1:IDX_W+2]),
    .rd_hit   (t_hit),
    .rd_target(t_tgt),
    .rd_insn  (t_insn),
    .rd_uncond(t_unc),
    .wr_en    (w_en),
    .wr_alloc (w_alloc),
    .wr_idx   (w_pc[IDX_W+1:2]),
    .wr_tag   (TAG_W'(w_pc[XLEN-1:IDX_W+2])),
    .wr_target(w_tgt),
    .wr_insn  (w_insn),
    .wr_uncond(w_unc)
  );

  btb_fetch_mux #(.XLEN(XLEN)) u_mux (
    .fetch_req  (fetch_req),
    .fetch_pc   (fetch_pc),
    .fetch_insn (fetch_insn),
    .stall      (fetch_stall),
    .redirect   (fetch_redirect),
    .redirect_pc(redirect_pc),
    .tbl_hit    (t_hit),
    .tbl_target (t_tgt),
    .tbl_insn   (t_insn),
    .tbl_uncond (t_unc),
    .next_pc    (next_pc),
    .dec_valid  (dec_valid),
    .dec_pred   (dec_pred),
    .dec_fold   (dec_fold),
    .dec_pc     (dec_pc),
    .dec_insn   (dec_insn)
  );
endmodule

// File: rtl/btb_fold_chk.sv
module btb_fold_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_stall,
  input logic            fetch_redirect,
  input logic            res_valid,
  input logic            res_ready,
  input logic            res_pred,
  input logic            res_taken,
  input logic            dec_valid,
  input logic            dec_pred,
  input logic            dec_fold,
  input logic [XLEN-1:0] dec_pc,
  input logic [XLEN-1:0] next_pc
);
  p_stall_then_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |=> fetch_redirect && !fetch_stall);

  p_restart_then_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_redirect |=> !fetch_redirect && !fetch_stall && res_ready);

  p_mispredict_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && (res_pred != res_taken)) |=> fetch_stall);

  p_agree_no_penalty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && (res_pred == res_taken)) |=> !fetch_stall && !fetch_redirect);

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stall || fetch_redirect) |-> !res_ready);

  p_update_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stall || fetch_redirect) |-> !dec_valid && !dec_pred);

  p_fold_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fold |-> dec_pred && (next_pc == dec_pc + XLEN'(4)));
endmodule

bind btb_fold_unit btb_fold_chk #(.XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetch_stall   (fetch_stall),
  .fetch_redirect(fetch_redirect),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_pred      (res_pred),
  .res_taken     (res_taken),
  .dec_valid     (dec_valid),
  .dec_pred      (dec_pred),
  .dec_fold      (dec_fold),
  .dec_pc        (dec_pc),
  .next_pc       (next_pc)
);

// File: tb/btb_fold_unit_test.sv
module btb_fold_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic [31:0] fetch_pc = '0, fetch_insn = '0;
  logic [31:0] next_pc, dec_pc, dec_insn, redirect_pc;
  logic        dec_valid, dec_pred, dec_fold, res_ready, fetch_stall, fetch_redirect;
  logic        res_valid = 1'b0, res_pred = 1'b0, res_taken = 1'b0, res_uncond = 1'b0;
  logic [31:0] res_pc = '0, res_target = '0, res_insn = '0;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference table kept by the bench
  bit        m_v   [16];
  bit [25:0] m_tag [16];

  always #10 clk = ~clk;

  btb_fold_unit uut (.*);

  function automatic [31:0] mk_pc(int idx, int tsel);
    return 32'h0000_1000 + (32'(tsel) << 6) + (32'(idx) << 2);
  endfunction
  function automatic [31:0] tgt_of(logic [31:0] pc);
    return ((pc * 3) + 32'h0000_4000) & 32'hFFFF_FFFC;
  endfunction
  function automatic [31:0] word_of(logic [31:0] pc);
    return pc ^ 32'hA5A5_0F0F;
  endfunction
  function automatic bit unc_of(logic [31:0] pc);
    return pc[7];  // tag select 2 gives unconditional branches
  endfunction
  function automatic bit m_hit(logic [31:0] pc);
    return m_v[pc[5:2]] && (m_tag[pc[5:2]] == pc[31:6]);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one branch: lookup, then resolution, then count penalty cycles
  task automatic do_branch(logic [31:0] pc, bit tk_sel);
    bit hit, unc, tk;
    int pen;
    logic [31:0] fw, exp_next, exp_rd;
    hit = m_hit(pc);
    unc = unc_of(pc);
    tk  = unc ? 1'b1 : tk_sel;
    fw  = $urandom;
    @(posedge clk); #1;
    fetch_req = 1'b1; fetch_pc = pc; fetch_insn = fw;
    @(negedge clk);
    chk(dec_valid == 1'b1, "R1 dec_valid", 32'(dec_valid), 32'd1);
    chk(dec_pred == hit, "R1 hit", 32'(dec_pred), 32'(hit));
    if (hit && unc) begin
      chk(dec_fold == 1'b1, "R4 fold", 32'(dec_fold), 32'd1);
      chk(dec_insn == word_of(pc), "R4 insn", dec_insn, word_of(pc));
      chk(dec_pc == tgt_of(pc), "R4 pc", dec_pc, tgt_of(pc));
      exp_next = tgt_of(pc) + 32'd4;
    end else begin
      chk(dec_fold == 1'b0, "R3 no fold", 32'(dec_fold), 32'd0);
      chk(dec_insn == fw, "R2 R3 insn", dec_insn, fw);
      exp_next = hit ? tgt_of(pc) : pc + 32'd4;
    end
    chk(next_pc == exp_next, hit ? "R2 next_pc" : "R3 next_pc", next_pc, exp_next);
    @(posedge clk); #1;
    res_valid = 1'b1; res_pc = pc; res_pred = hit; res_taken = tk;
    res_uncond = unc; res_target = tgt_of(pc); res_insn = word_of(pc);
    @(negedge clk);
    chk(res_ready == 1'b1, "R10 ready idle", 32'(res_ready), 32'd1);
    @(posedge clk); #1;
    res_valid = 1'b0;
    pen = 0;
    exp_rd = tk ? tgt_of(pc) : pc + 32'd4;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (fetch_stall || fetch_redirect) begin
        pen++;
        chk(res_ready == 1'b0, "R10 busy", 32'(res_ready), 32'd0);
        chk(!dec_valid && !dec_pred, "R11 no lookup", 32'(dec_valid), 32'd0);
      end
      if (c == 0 && hit != tk)
        chk(fetch_stall == 1'b1, "R6 R7 stall first", 32'(fetch_stall), 32'd1);
      if (fetch_redirect)
        chk(redirect_pc == exp_rd, tk ? "R7 redirect" : "R6 redirect", redirect_pc, exp_rd);
    end
    chk(pen == ((hit != tk) ? 2 : 0),
        (hit == tk) ? "R5 penalty" : (hit ? "R6 penalty" : "R7 penalty"),
        32'(pen), (hit != tk) ? 32'd2 : 32'd0);
    fetch_req = 1'b0;
    if (hit && !tk) m_v[pc[5:2]] = 1'b0;
    if (!hit && tk) begin
      m_v[pc[5:2]] = 1'b1;
      m_tag[pc[5:2]] = pc[31:6];
    end
  endtask

  task automatic probe(logic [31:0] pc, bit exp_hit, string req);
    @(posedge clk); #1;
    fetch_req = 1'b1; fetch_pc = pc;
    @(negedge clk);
    chk(dec_pred == exp_hit, req, 32'(dec_pred), 32'(exp_hit));
    fetch_req = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
  endtask

  initial begin
    logic [31:0] pa, pb, pu;
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!fetch_stall && !fetch_redirect && res_ready, "R9 reset idle",
        {29'd0, fetch_stall, fetch_redirect, res_ready}, 32'd1);
    for (int i = 0; i < 16; i++) probe(mk_pc(i, 1), 1'b0, "R9 empty after reset");

    pa = mk_pc(3, 0); pb = mk_pc(3, 1); pu = mk_pc(9, 2);
    do_branch(pa, 1'b0);                 // miss, not taken: R5
    do_branch(pa, 1'b1);                 // miss, taken: R7
    probe(pa, 1'b1, "R7 allocated");
    do_branch(pa, 1'b1);                 // hit, taken: R5, R2
    do_branch(pa, 1'b0);                 // hit, not taken: R6
    probe(pa, 1'b0, "R6 removed");
    do_branch(pu, 1'b1);                 // allocate unconditional
    do_branch(pu, 1'b1);                 // fold: R4
    do_branch(pa, 1'b1);
    do_branch(pb, 1'b1);                 // same slot, other tag: R8
    probe(pa, 1'b0, "R8 old evicted");
    probe(pb, 1'b1, "R8 new resident");
    do_reset();
    probe(pb, 1'b0, "R9 cleared");
    probe(pu, 1'b0, "R9 cleared");

    for (int n = 0; n < 400; n++)
      do_branch(mk_pc($urandom_range(0, 15), $urandom_range(0, 2)), 1'($urandom_range(0, 1)));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule